// File: doc/BRIEF.md
# FIFO-to-Handshake Core Harness

This block sits between a set of input FIFOs, a compute core and a set of output FIFOs, and runs one iteration per clock cycle. In each iteration it can take one sample from every input FIFO at once, hand that sample set to the core, and push each of the core's result lanes into its own output FIFO. The FIFOs are outside the block. Each input FIFO shows an empty flag, a head word and a pop strobe. The head word is valid in the same cycle. Each output FIFO shows a full flag, a push strobe and a data word.

A static parameter selects one of two modes. In plain mode the core is a pure per-iteration function. The harness raises a run strobe only when every input FIFO has data and no result is waiting. In handshake mode the core runs every cycle. The harness registers the core's ready-for-input flag and marks each delivered sample set with an input-valid flag. It obeys the core's output-valid flag and drives a ready-for-output flag back to the core.

If a result lane finds its output FIFO full, that lane keeps the word in its own holding register. The harness then drops ready-for-output until every held word has been written. The controller has two states. `ST_RUN` means no write is waiting. `ST_DRAIN` means at least one lane is holding a word. There are two transitions:
- **spill**: from `ST_RUN` to `ST_DRAIN`, when a result is accepted and any output FIFO is full.
- **clear**: from `ST_DRAIN` back to `ST_RUN`, in the cycle where no held word is blocked any longer.

Top module: `fifo_core_harness`

## Requirements
- R1: During and after reset no result is held, `core_rfo` is high, and the first cycle after reset treats the core as ready for input, so all input FIFOs are popped in that cycle when none is empty, whatever `core_rfi` was.
- R2: In plain mode, `core_run` and the pops are high exactly when every input FIFO is non-empty and no held write is outstanding.
- R3: In plain mode, while any output write is held, no input FIFO is popped and `core_run` stays low.
- R4: In handshake mode, input FIFOs are popped only if `core_rfi` was high in the previous cycle (or in the first cycle after reset), and only when all are non-empty.
- R5: In handshake mode, `core_run` is high in every cycle out of reset, and `core_in_valid` is low whenever any input FIFO is empty.
- R6: The input FIFOs are popped together or not at all, and `core_in_valid` is high exactly when they are popped.
- R7: While `core_out_valid` is low, and in plain mode also while `core_run` is low, no new result is pushed to any output FIFO.
- R8: A result accepted while an output FIFO is full is held for that lane. `core_rfo` is low from the next cycle on. The held word is offered again in every cycle, and `out_push` is never high for a full FIFO.
- R9: `core_rfo` stays low until every held word is written. A lane whose write has succeeded is not written again during that time. `core_out_valid` is ignored while `core_rfo` is low.
- R10: For each output FIFO, the k-th word pushed is the core's k-th accepted result lane. Every accepted result is eventually pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_empty | input | N_IN | Empty flag of each input FIFO |
| in_data | input | N_IN*W | Head words of the input FIFOs, lane i at bits [i*W +: W] |
| in_pop | output | N_IN | Pop strobe per input FIFO |
| out_full | input | N_OUT | Full flag of each output FIFO |
| out_push | output | N_OUT | Push strobe per output FIFO |
| out_data | output | N_OUT*W | Write words, lane j at bits [j*W +: W] |
| core_run | output | 1 | Iteration strobe to the core (constant high in handshake mode) |
| core_in_valid | output | 1 | Sample set on core_in_data is a fresh aligned set |
| core_in_data | output | N_IN*W | Sample set presented to the core |
| core_rfi | input | 1 | Core can take a sample set in the next cycle |
| core_out_valid | input | 1 | Core result on core_out_data is valid |
| core_out_data | input | N_OUT*W | Core result lanes |
| core_rfo | output | 1 | Core may produce a result this cycle |

## Verification
Two functions can fall in the same cycle: retrying a held output word, and popping a fresh sample set into the core. In handshake mode the core keeps running while `core_rfo` is low. The bench forces this overlap with per-cycle random full flags on the output FIFOs, while the input FIFOs stay mostly non-empty and `core_rfi` is mostly high. In that situation it also drives a garbage word with `core_out_valid` high. Each cycle is judged against a cycle model of the pop, push and ready flags that the bench builds from the requirements. Each output stream is compared, word by word, with results the bench computes from the input samples, so a misaligned pop, a lost retry or a leaked garbage word changes the stream.

// File: rtl/harness_pkg.sv
package harness_pkg;
    // Controller state: RUN when no output write is held, DRAIN while any lane holds one.
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } hstate_e;
endpackage

// File: rtl/hs_in_gate.sv
module hs_in_gate #(
    parameter int N_IN      = 2,
    parameter int HANDSHAKE = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] in_empty,
    input  logic            core_rfi,
    input  logic            drain,
    output logic [N_IN-1:0] in_pop,
    output logic            take
);
    logic rfi_q;
    logic all_ready;

    assign all_ready = ~(|in_empty);

    // Last cycle's ready-for-input; reset value models "ready" on the first iteration.
    always_ff @(posedge clk) begin
        if (rst) rfi_q <= 1'b1;
        else     rfi_q <= core_rfi;
    end

    generate
        if (HANDSHAKE != 0) begin : g_hs
            assign take = rfi_q & all_ready;
        end else begin : g_plain
            assign take = all_ready & ~drain;
        end
    endgenerate

    assign in_pop = {N_IN{take}};

    // R6: pops are all-or-none
    a_r6_pop_all_or_none: assert property (@(posedge clk) disable iff (rst)
        (in_pop == '0) || (in_pop == '1));
    // R2 / R4: never pop while some input FIFO is empty
    a_r4_no_pop_on_empty: assert property (@(posedge clk) disable iff (rst)
        (|in_pop) |-> !(|in_empty));
    // R3: plain mode stays idle on the input side while draining
    a_r3_no_pop_in_drain: assert property (@(posedge clk) disable iff (rst)
        (HANDSHAKE == 0 && drain) |-> (in_pop == '0));
endmodule

// File: rtl/hs_out_slot.sv
module hs_out_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  logic         full,
    input  logic [W-1:0] core_word,
    output logic         push,
    output logic [W-1:0] word,
    output logic         pending
);
    logic         pend_q;
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= '0;
        end else if (accept && full) begin
            pend_q <= 1'b1;
            held_q <= core_word;
        end else if (pend_q && !full) begin
            pend_q <= 1'b0;
        end
    end

    assign push    = (pend_q | accept) & ~full;
    assign word    = pend_q ? held_q : core_word;
    assign pending = pend_q;

    // R8: never push into a full FIFO
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R8: a blocked held word is kept for the next try
    a_r8_retry_kept: assert property (@(posedge clk) disable iff (rst)
        (pend_q && full) |=> (pend_q && $stable(held_q)));
    // R9: a lane that has written is not written again until a new accept
    a_r9_no_rewrite: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !full) |=> (!pend_q && (push == accept && push)) || !push);
endmodule

// File: rtl/fifo_core_harness.sv
module fifo_core_harness
    import harness_pkg::*;
#(
    parameter int N_IN      = 2,
    parameter int N_OUT     = 2,
    parameter int W         = 8,
    parameter int HANDSHAKE = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_IN-1:0]    in_empty,
    input  logic [N_IN*W-1:0]  in_data,
    output logic [N_IN-1:0]    in_pop,
    input  logic [N_OUT-1:0]   out_full,
    output logic [N_OUT-1:0]   out_push,
    output logic [N_OUT*W-1:0] out_data,
    output logic               core_run,
    output logic               core_in_valid,
    output logic [N_IN*W-1:0]  core_in_data,
    input  logic               core_rfi,
    input  logic               core_out_valid,
    input  logic [N_OUT*W-1:0] core_out_data,
    output logic               core_rfo
);
    hstate_e          state_q, state_d;
    logic             take;
    logic             drain;
    logic             accept;
    logic [N_OUT-1:0] pend;

    assign drain = (state_q == ST_DRAIN);

    hs_in_gate #(.N_IN(N_IN), .HANDSHAKE(HANDSHAKE)) u_in_gate (
        .clk      (clk),
        .rst      (rst),
        .in_empty (in_empty),
        .core_rfi (core_rfi),
        .drain    (drain),
        .in_pop   (in_pop),
        .take     (take)
    );

    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_slot
            hs_out_slot #(.W(W)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .accept    (accept),
                .full      (out_full[j]),
                .core_word (core_out_data[j*W +: W]),
                .push      (out_push[j]),
                .word      (out_data[j*W +: W]),
                .pending   (pend[j])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // Next state: spill on a blocked accept, clear when no held word stays blocked
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (accept && (|out_full))  state_d = ST_DRAIN;
            ST_DRAIN: if (!(|(pend & out_full)))  state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        core_rfo      = (state_q == ST_RUN);
        core_in_valid = take;
        core_in_data  = in_data;
        core_run      = (HANDSHAKE != 0) ? 1'b1 : take;
        accept        = core_out_valid && (state_q == ST_RUN) &&
                        ((HANDSHAKE != 0) || take);
    end

    // R9: ready-for-output is low whenever any lane holds a word
    a_r9_rfo_low_while_held: assert property (@(posedge clk) disable iff (rst)
        (|pend) |-> !core_rfo);
    // R9: the drain state always has a lane holding data
    a_r9_drain_has_pending: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN) |-> (|pend));
    // R8: a blocked accept drops ready-for-output on the next cycle
    a_r8_rfo_drops: assert property (@(posedge clk) disable iff (rst)
        (core_rfo && core_out_valid && core_run && (|out_full)) |=> !core_rfo);
    // R7: no push without a valid result or held word
    a_r7_push_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (!core_out_valid && !(|pend)) |-> (out_push == '0));
    // R5: handshake core runs every cycle
    a_r5_hs_runs: assert property (@(posedge clk) disable iff (rst)
        (HANDSHAKE != 0) |-> core_run);
endmodule

// File: tb/test_fifo_core_harness.sv
module harness_env #(
    parameter int HS = 1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_fail
);
    localparam int NI = 2;
    localparam int NO = 2;
    localparam int W  = 8;
    localparam int NS = 300;

    logic            rst;
    logic [NI-1:0]   in_empty;
    logic [NI*W-1:0] in_data;
    logic [NI-1:0]   in_pop;
    logic [NO-1:0]   out_full;
    logic [NO-1:0]   out_push;
    logic [NO*W-1:0] out_data;
    logic            core_run, core_in_valid, core_rfi, core_out_valid, core_rfo;
    logic [NI*W-1:0] core_in_data;
    logic [NO*W-1:0] core_out_data;

    fifo_core_harness #(.N_IN(NI), .N_OUT(NO), .W(W), .HANDSHAKE(HS)) i_fifo_core_harness (
        .clk(clk), .rst(rst), .in_empty(in_empty), .in_data(in_data), .in_pop(in_pop),
        .out_full(out_full), .out_push(out_push), .out_data(out_data),
        .core_run(core_run), .core_in_valid(core_in_valid), .core_in_data(core_in_data),
        .core_rfi(core_rfi), .core_out_valid(core_out_valid),
        .core_out_data(core_out_data), .core_rfo(core_rfo)
    );

    logic [W-1:0]    inq [NI][$];
    logic [W-1:0]    expq[NO][$];
    logic [NO*W-1:0] coreq[$];
    logic [31:0]     rs;
    logic            rfi_prev;
    logic [NO-1:0]   pend;

    function automatic logic [W-1:0] fcore(int j, logic [W-1:0] a, logic [W-1:0] b);
        return a ^ (b + W'(j * 37 + 5));
    endfunction

    function automatic logic [NO*W-1:0] fall(logic [NI*W-1:0] d);
        logic [NO*W-1:0] r;
        for (int j = 0; j < NO; j++) r[j*W +: W] = fcore(j, d[W-1:0], d[2*W-1:W]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s mode=%0d actual=%0h expected=%0h", req, HS, act, exp);
        end
    endtask

    task automatic step_rng();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    initial begin
        int  cyc;
        int  ethr, fthr, rthr;
        bit  all_ne, any_p, exp_take, acc;
        n_chk = 0; n_fail = 0; done = 1'b0;
        rs = 32'h1234_5678 + HS;
        rst = 1'b1; in_empty = '1; in_data = '0; out_full = '0;
        core_rfi = 1'b0; core_out_valid = 1'b0; core_out_data = '0;
        for (int k = 0; k < NS; k++) begin
            logic [W-1:0] a, b;
            a = W'(k * 3 + 1); b = W'(k * 7 + 100);
            inq[0].push_back(a); inq[1].push_back(b);
            for (int j = 0; j < NO; j++) expq[j].push_back(fcore(j, a, b));
        end
        // R1: reset state
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk(out_push == '0, "R1 no push in reset", out_push, 0);
            chk(in_pop == '0, "R1 no pop in reset (inputs empty)", in_pop, 0);
            chk(core_rfo == 1'b1, "R1 rfo high in reset", core_rfo, 1);
        end
        @(negedge clk);
        rst = 1'b0;
        rfi_prev = 1'b1; pend = '0;
        cyc = 0;
        while (cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            step_rng();
            ethr = (cyc < 4) ? 0 : 40 * int'(rs[31:30]);
            fthr = (cyc < 4) ? 0 : 50 * int'(rs[29:28] ^ 2'(cyc >> 8));
            rthr = (cyc < 4) ? 256 : 200 - 40 * int'(rs[27:26]);
            for (int i = 0; i < NI; i++) begin
                step_rng();
                in_empty[i] = (inq[i].size() == 0) || (int'(rs[7:0]) < ethr);
                in_data[i*W +: W] = (inq[i].size() != 0) ? inq[i][0] : 8'h00;
            end
            for (int j = 0; j < NO; j++) begin
                step_rng();
                out_full[j] = int'(rs[7:0]) < fthr;
            end
            step_rng();
            core_rfi = (cyc < 4) ? 1'b0 : (int'(rs[7:0]) < rthr);
            if (HS != 0) begin
                if (core_rfo) begin
                    core_out_valid = (coreq.size() != 0);
                    core_out_data  = (coreq.size() != 0) ? coreq[0] : '0;
                end else begin
                    core_out_valid = rs[9];         // R9: must be ignored
                    core_out_data  = {NO{8'hEE}};
                end
            end else begin
                core_out_valid = 1'b1;
                core_out_data  = fall(in_data);
            end
            #1;
            all_ne = ~(|in_empty);
            any_p  = |pend;
            exp_take = (HS != 0) ? (rfi_prev && all_ne) : (all_ne && !any_p);
            if (cyc == 0) chk(in_pop == '1, "R1 first iteration pops", in_pop, 3);
            if (HS != 0 && cyc == 1) chk(in_pop == '0, "R4 no pop after rfi low", in_pop, 0);
            chk(in_pop == {NI{exp_take}}, (HS != 0) ? "R4 pop gating" : "R2 pop gating",
                in_pop, {NI{exp_take}});
            chk(core_in_valid == exp_take, "R6 in_valid matches pops", core_in_valid, exp_take);
            if (HS != 0) begin
                chk(core_run == 1'b1, "R5 core runs every cycle", core_run, 1);
                if (!all_ne) chk(!core_in_valid, "R5 in_valid low on empty", core_in_valid, 0);
            end else begin
                chk(core_run == exp_take, "R2 run strobe", core_run, exp_take);
                if (any_p) chk(in_pop == '0 && !core_run, "R3 idle while held", in_pop, 0);
            end
            chk(core_rfo == !any_p, "R9 rfo tracks held words", core_rfo, !any_p);
            acc = core_out_valid && !any_p && ((HS != 0) || exp_take);
            for (int j = 0; j < NO; j++) begin
                bit ep;
                ep = (pend[j] || acc) && !out_full[j];
                chk(out_push[j] == ep, (pend[j] || acc) ? "R8 retry/push" : "R7 no push",
                    out_push[j], ep);
                if (out_push[j]) begin
                    logic [W-1:0] e;
                    e = (expq[j].size() != 0) ? expq[j][0] : 8'h00;
                    chk(expq[j].size() != 0 && out_data[j*W +: W] == e, "R10 stream order",
                        out_data[j*W +: W], e);
                    if (expq[j].size() != 0) void'(expq[j].pop_front());
                end
                if (acc && out_full[j]) pend[j] = 1'b1;
                else if (pend[j] && !out_full[j]) pend[j] = 1'b0;
            end
            if (in_pop == '1) begin
                if (HS != 0) coreq.push_back(fall(in_data));
                for (int i = 0; i < NI; i++) if (inq[i].size() != 0) void'(inq[i].pop_front());
            end
            if (HS != 0 && acc && coreq.size() != 0) void'(coreq.pop_front());
            rfi_prev = core_rfi;
            cyc++;
            if (expq[0].size() == 0 && expq[1].size() == 0 && pend == '0 && cyc > 8) break;
        end
        for (int j = 0; j < NO; j++)
            chk(expq[j].size() == 0, "R10 all results delivered", expq[j].size(), 0);
        done = 1'b1;
    end
endmodule

module test_fifo_core_harness;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic done_h, done_p;
    int   chk_h, fail_h, chk_p, fail_p;

    harness_env #(.HS(1)) u_env_hs    (.clk(clk), .done(done_h), .n_chk(chk_h), .n_fail(fail_h));
    harness_env #(.HS(0)) u_env_plain (.clk(clk), .done(done_p), .n_chk(chk_p), .n_fail(fail_p));

    initial begin
        int wd;
        int tot, bad;
        wd = 0;
        while (!(done_h === 1'b1 && done_p === 1'b1) && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        tot = chk_h + chk_p;
        bad = fail_h + fail_p;
        if (wd >= 100000) begin
            tot++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
        end
        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end
endmodule